// File: doc/BRIEF.md
# Flash Data-Polling Status Generator

This block sits in the read-data path of a flash array controller. While an embedded program or erase algorithm runs, it replaces the most significant bit of each read byte with a polling flag. Software polls that flag to learn whether the algorithm is still busy, has finished, is suspended, or has failed. The low seven bits always come straight from the array.

A small sequencer tracks the algorithm phase: idle, programming, sector-erase wait, erasing, erase suspended, failed program and failed erase. A sector-erase command latches a per-sector mask. A chip-erase command sets every bit of that mask. For the erase phases, the flag depends on whether the read address falls in a masked sector. The array is a behavioural memory. Completion and failure of an algorithm come in as strobes from outside, and the sector-erase wait period is a fixed count of cycles.

Top module: `flash_poll_status`

## Requirements
- R1: Synchronous active-low reset puts the block in the idle phase, clears the sector mask, and sets every array byte to 0xFF.
- R2: In the idle phase, `rd_data` equals the stored byte at `rd_addr`, all bits included.
- R3: While programming, every read returns bit 7 as the complement of bit 7 of the byte being programmed, whatever the address.
- R4: `alg_done` while programming (with `alg_fail` low) stores `cmd_data` at `cmd_addr` and returns to idle. After that, the true stored bit 7 is read back.
- R5: A sector-erase command holds a wait phase of WAIT_CYC cycles and then enters erasing. In both phases, reads of a masked sector return bit 7 = 0, and reads of other sectors return the true byte. Sector index = the top SECT_W address bits; mask bit i covers sector i.
- R6: A chip-erase command sets every mask bit and enters erasing directly, so every read returns bit 7 = 0.
- R7: `alg_done` while erasing sets every byte of every masked sector to 0xFF and returns to idle, so those bytes then read bit 7 = 1.
- R8: `cmd_suspend` during a sector erase that is in the erasing phase makes masked-sector reads return bit 7 = 1, while other sectors read true. `cmd_resume` returns the flag to 0. A suspend is ignored during the wait phase and during a chip erase.
- R9: `alg_fail` during programming keeps the complemented bit 7 on every read. `alg_fail` during the wait or erasing phase makes every read return bit 7 = 0. A failed phase leaves the array unchanged, and only `cmd_reset` returns the block to idle.
- R10: Start commands are accepted only in idle, with priority program > chip erase > sector erase. `alg_done` and `alg_fail` are ignored in idle and while suspended.
- R11: Bits 6 to 0 of `rd_data` always equal the stored array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_prog | input | 1 | Start programming strobe |
| cmd_chip_erase | input | 1 | Start chip erase strobe |
| cmd_sect_erase | input | 1 | Start sector erase strobe |
| cmd_suspend | input | 1 | Suspend sector erase strobe |
| cmd_resume | input | 1 | Resume sector erase strobe |
| cmd_reset | input | 1 | Leave a failed phase strobe |
| alg_done | input | 1 | Algorithm completion strobe |
| alg_fail | input | 1 | Algorithm failure strobe |
| cmd_addr | input | ADDR_W | Program address |
| cmd_data | input | DATA_W | Program byte |
| sect_sel | input | 2**SECT_W | Sector mask for sector erase |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data with polling flag in bit 7 |

## Verification
The bench builds the block with ADDR_W=6, SECT_W=2 and WAIT_CYC=4: a 64-byte array in four sectors of 16 bytes. At that size, every address can be swept in every phase, including masked and unmasked sectors, suspended and failed phases, and idle after each completion. A bench-side reference of the array and the phase computes each expected byte arithmetically. Every one of the 64 bytes is programmed with a distinct pattern, so both values of bit 7 occur.

// File: rtl/fpoll_pkg.sv
`timescale 1ns/1ps
// Shared types for the flash data-polling status generator.
package fpoll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_EWAIT = 3'd2,
        ST_ERASE = 3'd3,
        ST_SUSP  = 3'd4,
        ST_FAILP = 3'd5,
        ST_FAILE = 3'd6
    } fpoll_st_e;
endpackage

// File: rtl/fpoll_seq.sv
`timescale 1ns/1ps
// Algorithm phase sequencer.
// Tracks the program/erase phase, latches the program target and the sector
// mask, and emits one-cycle commit pulses for the array.
// Assumes all command and completion inputs are single-cycle strobes.
module fpoll_seq #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int NSECT    = 4,
    parameter int WAIT_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_prog,
    input  logic                   cmd_chip_erase,
    input  logic                   cmd_sect_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_resume,
    input  logic                   cmd_reset,
    input  logic                   alg_done,
    input  logic                   alg_fail,
    input  logic [ADDR_W-1:0]      cmd_addr,
    input  logic [DATA_W-1:0]      cmd_data,
    input  logic [NSECT-1:0]       sect_sel,
    output fpoll_pkg::fpoll_st_e   st,
    output logic [ADDR_W-1:0]      prog_addr,
    output logic [DATA_W-1:0]      prog_data,
    output logic [NSECT-1:0]       er_mask,
    output logic                   chip_q,
    output logic                   wr_commit,
    output logic                   er_commit
);
    import fpoll_pkg::*;

    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] wait_cnt;

    // Commit pulses: a successful completion in the matching phase.
    always_comb begin
        wr_commit = (st == ST_PROG)  && alg_done && !alg_fail;
        er_commit = (st == ST_ERASE) && alg_done && !alg_fail;
    end

    // Phase register, wait counter and latched command operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            wait_cnt  <= '0;
            prog_addr <= '0;
            prog_data <= '0;
            er_mask   <= '0;
            chip_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cmd_prog) begin
                        st        <= ST_PROG;
                        prog_addr <= cmd_addr;
                        prog_data <= cmd_data;
                    end else if (cmd_chip_erase) begin
                        st      <= ST_ERASE;
                        er_mask <= '1;
                        chip_q  <= 1'b1;
                    end else if (cmd_sect_erase) begin
                        st       <= ST_EWAIT;
                        er_mask  <= sect_sel;
                        chip_q   <= 1'b0;
                        wait_cnt <= '0;
                    end
                end
                ST_PROG: begin
                    if (alg_fail)      st <= ST_FAILP;
                    else if (alg_done) st <= ST_IDLE;
                end
                ST_EWAIT: begin
                    if (alg_fail)                  st <= ST_FAILE;
                    else if (wait_cnt == WAIT_LAST) st <= ST_ERASE;
                    else                           wait_cnt <= wait_cnt + 1'b1;
                end
                ST_ERASE: begin
                    if (alg_fail)                    st <= ST_FAILE;
                    else if (alg_done)               st <= ST_IDLE;
                    else if (cmd_suspend && !chip_q) st <= ST_SUSP;
                end
                ST_SUSP: begin
                    if (cmd_resume) st <= ST_ERASE;
                end
                ST_FAILP, ST_FAILE: begin
                    if (cmd_reset) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fpoll_array.sv
`timescale 1ns/1ps
// Behavioural flash array.
// One register per byte; erase commit fills masked sectors with all ones,
// program commit writes one byte. Read is combinational.
// Assumes erase and program commits never coincide (sequencer guarantees).
module fpoll_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SECT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_commit,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    er_commit,
    input  logic [(1<<SECT_W)-1:0]  er_mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_q
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SOFF  = ADDR_W - SECT_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam int SIDX = g >> SOFF;
        // Per-byte storage: reset and erase to ones, program overwrites.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '1;
            else if (er_commit && er_mask[SIDX])
                mem[g] <= '1;
            else if (wr_commit && (wr_addr == ADDR_W'(g)))
                mem[g] <= wr_data;
        end
    end

    // Combinational read port.
    always_comb rd_q = mem[rd_addr];
endmodule

// File: rtl/fpoll_flag_mux.sv
`timescale 1ns/1ps
// Read-data flag multiplexer.
// Replaces the top data bit with the polling flag for the current phase and
// passes the remaining bits unchanged. Purely combinational.
module fpoll_flag_mux #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SECT_W = 2
) (
    input  fpoll_pkg::fpoll_st_e    st,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [DATA_W-1:0]       arr_q,
    input  logic [(1<<SECT_W)-1:0]  er_mask,
    input  logic                    prog_msb,
    output logic [DATA_W-1:0]       rd_data
);
    import fpoll_pkg::*;

    localparam int MSB = DATA_W - 1;

    logic in_sect;
    logic flag;

    // Membership of the read address in the latched erase mask.
    always_comb in_sect = er_mask[rd_addr[ADDR_W-1 -: SECT_W]];

    // Flag selection per phase.
    always_comb begin
        case (st)
            ST_PROG, ST_FAILP:  flag = ~prog_msb;
            ST_EWAIT, ST_ERASE: flag = in_sect ? 1'b0 : arr_q[MSB];
            ST_SUSP:            flag = in_sect ? 1'b1 : arr_q[MSB];
            ST_FAILE:           flag = 1'b0;
            default:            flag = arr_q[MSB];
        endcase
    end

    // Output assembly.
    always_comb rd_data = {flag, arr_q[MSB-1:0]};
endmodule

// File: rtl/flash_poll_status.sv
`timescale 1ns/1ps
// Flash data-polling status generator, top level.
// Connects the phase sequencer, the behavioural array and the flag mux.
// Assumes single-cycle command strobes, synchronous active-low reset.
module flash_poll_status #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int SECT_W   = 2,
    parameter int WAIT_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_prog,
    input  logic                    cmd_chip_erase,
    input  logic                    cmd_sect_erase,
    input  logic                    cmd_suspend,
    input  logic                    cmd_resume,
    input  logic                    cmd_reset,
    input  logic                    alg_done,
    input  logic                    alg_fail,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [DATA_W-1:0]       cmd_data,
    input  logic [(1<<SECT_W)-1:0]  sect_sel,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int NSECT = 1 << SECT_W;

    fpoll_pkg::fpoll_st_e  st;
    logic [ADDR_W-1:0]     prog_addr;
    logic [DATA_W-1:0]     prog_data;
    logic [NSECT-1:0]      er_mask;
    logic                  chip_q;
    logic                  wr_commit;
    logic                  er_commit;
    logic [DATA_W-1:0]     arr_q;

    fpoll_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSECT(NSECT), .WAIT_CYC(WAIT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_prog(cmd_prog), .cmd_chip_erase(cmd_chip_erase),
        .cmd_sect_erase(cmd_sect_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .alg_done(alg_done), .alg_fail(alg_fail),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sect_sel(sect_sel),
        .st(st), .prog_addr(prog_addr), .prog_data(prog_data),
        .er_mask(er_mask), .chip_q(chip_q),
        .wr_commit(wr_commit), .er_commit(er_commit)
    );

    fpoll_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_commit(wr_commit), .wr_addr(prog_addr), .wr_data(prog_data),
        .er_commit(er_commit), .er_mask(er_mask),
        .rd_addr(rd_addr), .rd_q(arr_q)
    );

    fpoll_flag_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
    ) u_mux (
        .st(st), .rd_addr(rd_addr), .arr_q(arr_q), .er_mask(er_mask),
        .prog_msb(prog_data[DATA_W-1]), .rd_data(rd_data)
    );
endmodule

// File: rtl/fpoll_chk.sv
`timescale 1ns/1ps
// Assertion checker for the flash data-polling status generator.
// Observes top-level ports and the phase, mask and array read value.
module fpoll_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int SECT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_reset,
    input  fpoll_pkg::fpoll_st_e    st,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [DATA_W-1:0]       rd_data,
    input  logic [DATA_W-1:0]       arr_q,
    input  logic [(1<<SECT_W)-1:0]  er_mask,
    input  logic                    chip_q,
    input  logic                    prog_msb
);
    import fpoll_pkg::*;

    localparam int MSB = DATA_W - 1;

    logic in_sect;
    always_comb in_sect = er_mask[rd_addr[ADDR_W-1 -: SECT_W]];

    AST_IDLE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (rd_data == arr_q)); // R2
    AST_PROG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |-> (rd_data[MSB] == !prog_msb)); // R3
    AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_ERASE || st == ST_EWAIT) && in_sect) |-> !rd_data[MSB]); // R5
    AST_CHIP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && chip_q) |-> (&er_mask)); // R6
    AST_SUSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && in_sect) |-> rd_data[MSB]); // R8
    AST_NO_CHIP_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |-> !chip_q); // R8
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_FAILP || st == ST_FAILE) && !cmd_reset) |=> (st == $past(st))); // R9
    AST_FAIL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_FAILP || st == ST_FAILE) && cmd_reset) |=> (st == ST_IDLE)); // R9
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rd_data[MSB-1:0] == arr_q[MSB-1:0])); // R11
endmodule

bind flash_poll_status fpoll_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .st(st),
    .rd_addr(rd_addr), .rd_data(rd_data), .arr_q(arr_q),
    .er_mask(er_mask), .chip_q(chip_q), .prog_msb(prog_data[DATA_W-1])
);

// File: tb/flash_poll_status_tb.sv
`timescale 1ns/1ps
module flash_poll_status_tb;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 8;
    localparam int SECT_W   = 2;
    localparam int WAIT_CYC = 4;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int NSECT    = 1 << SECT_W;
    localparam int SOFF     = ADDR_W - SECT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_prog = 0, cmd_chip_erase = 0, cmd_sect_erase = 0;
    logic cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0;
    logic alg_done = 0, alg_fail = 0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic [NSECT-1:0]  sect_sel = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;

    int total = 0;
    int bad = 0;

    // Reference model: array contents and phase.
    // ph: 0 idle, 1 programming, 2 erase wait/erasing, 3 suspended,
    //     4 failed program, 5 failed erase
    logic [7:0] ref_mem [DEPTH];
    int         ph = 0;
    logic       lastb7 = 1'b0;
    logic [NSECT-1:0] rmask = '0;
    logic [ADDR_W-1:0] pa = '0;
    logic [7:0] pd = '0;

    always #4 clk = ~clk;

    flash_poll_status #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .WAIT_CYC(WAIT_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_prog(cmd_prog), .cmd_chip_erase(cmd_chip_erase),
        .cmd_sect_erase(cmd_sect_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .alg_done(alg_done), .alg_fail(alg_fail),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sect_sel(sect_sel),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] expv(input int a);
        logic [7:0] m;
        logic in_s;
        m = ref_mem[a];
        in_s = rmask[a >> SOFF];
        case (ph)
            1, 4: m[7] = ~lastb7;
            2:    if (in_s) m[7] = 1'b0;
            3:    if (in_s) m[7] = 1'b1;
            5:    m[7] = 1'b0;
            default: ;
        endcase
        return m;
    endfunction

    task automatic read_chk(input string req, input int a);
        rd_addr = ADDR_W'(a);
        #1;
        total++;
        if (rd_data !== expv(a)) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rd_data, expv(a));
        end
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) read_chk(req, a);
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Strobe helpers: assert at a falling edge, drop at the next one.
    task automatic do_prog(input int a, input logic [7:0] d);
        @(negedge clk); cmd_prog = 1; cmd_addr = ADDR_W'(a); cmd_data = d;
        @(negedge clk); cmd_prog = 0;
    endtask
    task automatic do_done;
        @(negedge clk); alg_done = 1;
        @(negedge clk); alg_done = 0;
    endtask
    task automatic do_fail;
        @(negedge clk); alg_fail = 1;
        @(negedge clk); alg_fail = 0;
    endtask
    task automatic do_susp;
        @(negedge clk); cmd_suspend = 1;
        @(negedge clk); cmd_suspend = 0;
    endtask
    task automatic do_resume;
        @(negedge clk); cmd_resume = 1;
        @(negedge clk); cmd_resume = 0;
    endtask
    task automatic do_rst_cmd;
        @(negedge clk); cmd_reset = 1;
        @(negedge clk); cmd_reset = 0;
    endtask
    task automatic do_sect(input logic [NSECT-1:0] m);
        @(negedge clk); cmd_sect_erase = 1; sect_sel = m;
        @(negedge clk); cmd_sect_erase = 0;
    endtask
    task automatic do_chip;
        @(negedge clk); cmd_chip_erase = 1;
        @(negedge clk); cmd_chip_erase = 0;
    endtask

    task automatic ref_erase_done;
        for (int a = 0; a < DEPTH; a++)
            if (rmask[a >> SOFF]) ref_mem[a] = 8'hFF;
        ph = 0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, whole array erased, idle phase
        sweep("R1");

        // R3/R4: program every byte with a distinct pattern
        for (int a = 0; a < DEPTH; a++) begin
            pa = ADDR_W'(a); pd = 8'(a * 73 + 29);
            do_prog(a, pd);
            ph = 1; lastb7 = pd[7];
            read_chk("R3", a);
            read_chk("R3", (a + 17) % DEPTH);
            do_done();
            ref_mem[a] = pd; ph = 0;
            read_chk("R4", a);
        end
        // R2/R11: idle returns true bytes everywhere
        sweep("R2");

        // R10: chip erase during programming is ignored
        do_prog(3, 8'h55);
        ph = 1; lastb7 = 1'b0;
        do_chip();
        sweep("R10");
        do_done();
        ref_mem[3] = 8'h55; ph = 0;
        sweep("R10");
        // R10: completion and failure strobes ignored in idle
        do_done();
        do_fail();
        sweep("R10");

        // R5: sector erase of sectors 0 and 2
        do_sect(4'b0101);
        ph = 2; rmask = 4'b0101;
        // R8: a suspend during the wait phase is ignored
        do_susp();
        read_chk("R8", 0);
        repeat (WAIT_CYC + 2) @(negedge clk);
        sweep("R5");
        // R8: suspend in erasing, masked sectors read 1
        do_susp();
        ph = 3;
        sweep("R8");
        // R10: completion while suspended is ignored
        do_done();
        sweep("R10");
        // R8: resume returns the flag to 0
        do_resume();
        ph = 2;
        sweep("R8");
        // R7: completion fills masked sectors with ones
        do_done();
        ref_erase_done();
        sweep("R7");

        // R6: chip erase masks every sector
        do_chip();
        ph = 2; rmask = '1;
        sweep("R6");
        // R8: suspend ignored during chip erase
        do_susp();
        sweep("R8");
        do_done();
        ref_erase_done();
        sweep("R7");

        // Refill a few bytes with varied patterns
        for (int a = 0; a < 24; a++) begin
            pd = 8'(a * 151 + 7);
            do_prog(a, pd);
            do_done();
            ref_mem[a] = pd;
        end
        sweep("R4");

        // R9: programming failure holds complemented flag
        do_prog(20, 8'h80);
        ph = 1; lastb7 = 1'b1;
        do_fail();
        ph = 4;
        sweep("R9");
        do_prog(5, 8'h00);
        do_done();
        sweep("R9");
        do_rst_cmd();
        ph = 0;
        sweep("R9");

        // R9: erase failure forces 0 everywhere, array untouched
        do_sect(4'b0010);
        ph = 2; rmask = 4'b0010;
        repeat (WAIT_CYC + 2) @(negedge clk);
        do_fail();
        ph = 5;
        sweep("R9");
        do_resume();
        sweep("R9");
        do_rst_cmd();
        ph = 0;
        sweep("R9");

        finish_run();
    end
endmodule